// File: doc/BRIEF.md
# Self-Stopping Twisted-Ring Counter

This block is a seven-bit twisted-ring counter that walks its code sequence from the all-zeros start code. It stops for good on one terminal code, the code that comes right after all ones. Each advance shifts the state one place toward the most significant bit and feeds the complement of the old top bit into bit 0. A decode of the current state sees the terminal code, and from then on the next-state logic reloads the present value on every clock. The clock itself runs freely and is never gated.

The counter leaves the terminal code only through the active-high synchronous reset or through a synchronous restart request. Both load the start code. A count enable lets the counter pause anywhere before the terminal code. A typical use is a test sequencer that presents a fixed run of patterns and then parks on its last one until it is restarted.

Top module: `self_stop_johnson`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `count_q` becomes 0000000 at that edge and `term_hit` is low afterwards.
- R2: When `rst` and `restart` are low, `count_en` is high and the state is not terminal, the next state is the old bits [5:0] in bits [6:1], with the inverse of the old bit 6 in bit 0.
- R3: Starting from 0000000 with `count_en` held high, the state passes 0000001, 0000011, up to 1111111. It reaches the terminal code 1111110 on the eighth enabled edge.
- R4: Once the state is 1111110, it stays 1111110 on every later edge whatever `count_en` is, unless `rst` or `restart` is high.
- R5: `term_hit` is high exactly when `count_q` equals 1111110, in the same cycle, with no register in between.
- R6: With `rst` and `restart` low and `count_en` low, the state does not change.
- R7: `restart` high (with `rst` low) loads 0000000 at the next edge. It wins over the terminal hold and over `count_en`.
- R8: `rst` wins over `restart`, and both act only at a clock edge (synchronous).
- R9: Apart from edges where `rst` or `restart` is high, at most one bit of `count_q` changes per edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset to the start code |
| count_en | input | 1 | Advance enable |
| restart | input | 1 | Synchronous request to reload the start code |
| count_q | output | 7 | Current counter state |
| term_hit | output | 1 | High while the state is the terminal code |

## Verification
On every cycle, the embedded assertions check the one-step shift rule, the hold when the counter is disabled, the hold on the terminal code, the return to zero on restart or reset, and the single-bit-change property. Only the bench's scenarios can show that the terminal code is reached after exactly eight enabled edges and not earlier. The same holds for how reset and restart are ordered when both are raised together, and for how long parking lasts under random enable activity; the bench checks each of these against its own model of the sequence.

// File: rtl/jc_pkg.sv
package jc_pkg;

    localparam int JC_DEFAULT_WIDTH = 7;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_STEP   = 2'd1,
        ACT_RELOAD = 2'd2,
        ACT_PARK   = 2'd3
    } jc_act_e;

    typedef struct packed {
        logic restart;
        logic enable;
    } jc_ctrl_t;

endpackage

// File: rtl/jc_term_decode.sv
module jc_term_decode #(
    parameter int WIDTH = jc_pkg::JC_DEFAULT_WIDTH
) (
    input  logic [WIDTH-1:0] state,
    output logic             at_term
);
    localparam logic [WIDTH-1:0] TERM_CODE = {{(WIDTH-1){1'b1}}, 1'b0};

    always_comb begin
        at_term = (state == TERM_CODE);
    end
endmodule

// File: rtl/jc_step_sel.sv
module jc_step_sel #(
    parameter int WIDTH = jc_pkg::JC_DEFAULT_WIDTH
) (
    input  logic [WIDTH-1:0] state,
    input  jc_pkg::jc_ctrl_t ctrl,
    input  logic             at_term,
    output logic [WIDTH-1:0] next_state
);
    import jc_pkg::*;

    localparam logic [WIDTH-1:0] START_CODE = '0;

    jc_act_e act;

    always_comb begin
        if (ctrl.restart)     act = ACT_RELOAD;
        else if (at_term)     act = ACT_PARK;
        else if (ctrl.enable) act = ACT_STEP;
        else                  act = ACT_HOLD;
    end

    always_comb begin
        unique case (act)
            ACT_RELOAD: next_state = START_CODE;
            ACT_STEP:   next_state = {state[WIDTH-2:0], ~state[WIDTH-1]};
            default:    next_state = state;
        endcase
    end
endmodule

// File: rtl/jc_state_reg.sv
module jc_state_reg #(
    parameter int WIDTH = jc_pkg::JC_DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    AST_RST_CLEARS: assert property (@(posedge clk) rst |=> (q == '0)); // R1
endmodule

// File: rtl/self_stop_johnson.sv
module self_stop_johnson #(
    parameter int WIDTH = jc_pkg::JC_DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             count_en,
    input  logic             restart,
    output logic [WIDTH-1:0] count_q,
    output logic             term_hit
);
    import jc_pkg::*;

    localparam logic [WIDTH-1:0] TERM_CODE = {{(WIDTH-1){1'b1}}, 1'b0};

    jc_ctrl_t         ctrl;
    logic [WIDTH-1:0] next_state;
    logic [WIDTH-1:0] state_q;
    logic             at_term;

    always_comb begin
        ctrl.restart = restart;
        ctrl.enable  = count_en;
    end

    jc_term_decode #(.WIDTH(WIDTH)) u_decode (
        .state   (state_q),
        .at_term (at_term)
    );

    jc_step_sel #(.WIDTH(WIDTH)) u_step (
        .state      (state_q),
        .ctrl       (ctrl),
        .at_term    (at_term),
        .next_state (next_state)
    );

    jc_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk (clk),
        .rst (rst),
        .d   (next_state),
        .q   (state_q)
    );

    assign count_q  = state_q;
    assign term_hit = at_term;

    AST_STEP_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (!restart && count_en && state_q != TERM_CODE)
        |=> (state_q == {$past(state_q[WIDTH-2:0]), ~$past(state_q[WIDTH-1])})); // R2
    AST_TERM_PARK: assert property (@(posedge clk) disable iff (rst)
        (!restart && term_hit) |=> ($stable(state_q) && term_hit)); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!restart && !count_en) |=> $stable(state_q)); // R6
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
        restart |=> (state_q == '0)); // R7
    AST_ONE_BIT_MOVE: assert property (@(posedge clk) disable iff (rst)
        !restart |=> $onehot0(state_q ^ $past(state_q))); // R9
endmodule

// File: tb/self_stop_johnson_bench.sv
`timescale 1ns/1ps
module self_stop_johnson_bench;
    localparam int W = 7;
    localparam logic [W-1:0] TERM = 7'b1111110;

    logic         clk = 1'b0;
    logic         rst, count_en, restart;
    logic [W-1:0] count_q;
    logic         term_hit;
    logic [W-1:0] model;
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    self_stop_johnson #(.WIDTH(W)) u_self_stop_johnson (
        .clk(clk), .rst(rst), .count_en(count_en), .restart(restart),
        .count_q(count_q), .term_hit(term_hit)
    );

    function automatic logic [W-1:0] exp_next(logic [W-1:0] s, logic r, logic rs, logic en);
        if (r)              return '0;
        else if (rs)        return '0;
        else if (s == TERM) return s;
        else if (en)        return {s[W-2:0], ~s[W-1]};
        else                return s;
    endfunction

    task automatic chk(string req, logic [W-1:0] got, logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic step(logic r, logic rs, logic en, string req);
        logic [W-1:0] prev;
        @(negedge clk);
        rst = r; restart = rs; count_en = en;
        prev = model;
        @(posedge clk);
        model = exp_next(model, r, rs, en);
        #1;
        chk(req, count_q, model);
        chk("R5", {6'd0, term_hit}, {6'd0, model == TERM});
        if (!r && !rs && $countones(count_q ^ prev) > 1) begin
            n_chk++; n_bad++;
            $display("FAIL R9: got %b expected at most one bit from %b", count_q, prev);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 17;
        void'($urandom(seed));
        rst = 1'b1; restart = 1'b0; count_en = 1'b0; model = '0;
        step(1, 0, 0, "R1");
        step(1, 0, 1, "R1");
        chk("R1", {6'd0, term_hit}, 7'd0);
        // R3: eight enabled edges reach the terminal code, not earlier
        for (int i = 1; i <= 8; i++) begin
            step(0, 0, 1, "R3");
            chk("R3", {6'd0, term_hit}, {6'd0, i == 8});
        end
        chk("R3", count_q, 7'b1111110);
        // R4: parked regardless of enable
        step(0, 0, 1, "R4");
        step(0, 0, 0, "R4");
        step(0, 0, 1, "R4");
        // R7: restart leaves the terminal code
        step(0, 1, 1, "R7");
        chk("R7", count_q, 7'd0);
        // R6: hold while disabled mid-sequence
        step(0, 0, 1, "R2");
        step(0, 0, 1, "R2");
        step(0, 0, 0, "R6");
        chk("R6", count_q, 7'b0000011);
        // R8: reset together with restart
        step(0, 0, 1, "R2");
        step(1, 1, 1, "R8");
        // R7: restart wins over enable mid-sequence
        step(0, 0, 1, "R2");
        step(0, 1, 1, "R7");
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic r, rs, en;
            r  = ($urandom % 64) == 0;
            rs = ($urandom % 24) == 0;
            en = ($urandom % 4) != 0;
            step(r, rs, en, r ? "R8" : rs ? "R7" : (model == TERM) ? "R4" : en ? "R2" : "R6");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule